// File: doc/BRIEF.md
# Self-Correcting Ring Counter

This block is a four-stage shift-register counter that carries exactly one marked bit around its stages. Each clock moves the mark one stage toward the most significant output, so the outputs step through four states and return to the first. The counter can be used as a modulo-4 counter or as a source of phased, non-overlapping strobes.

The bit that enters the lowest stage is not taken from the top stage. It is formed from the three lower stages: it is the marked value only when none of those stages holds the mark. Because of this, any stray pattern is cleared within a few clocks, and the counter falls back into the valid four-state cycle.

A parameter selects how the mark is coded. In one setting the mark is a single 1 among 0s. In the other it is a single 0 among 1s. A synchronous reset loads the first state of the cycle. A test-only load input places any pattern in the stages, so that recovery from illegal states can be exercised.

Top module: `ring_sc`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes 0001 with the active-high code (`ACTIVE_LOW`=0) or 1110 with the active-low code (`ACTIVE_LOW`=1). This holds even when `tst_load` is high at the same edge.
- R2: When neither `rst` nor `tst_load` is high at an edge, each bit `q[i]` for i≥1 takes the previous value of `q[i-1]`.
- R3: With the active-high code, on a shifting edge `q[0]` becomes 1 exactly when `q[2:0]` was 000 before the edge.
- R4: With the active-low code, on a shifting edge `q[0]` becomes 0 exactly when `q[2:0]` was 111 before the edge.
- R5: Once `q` holds a valid state, shifting edges keep it in a valid state. A valid state has exactly one bit at the marked value: 1 for the active-high code, 0 for the active-low code.
- R6: The valid states follow this order, where the mark moves from bit 0 up to bit 3 and then wraps: 0001, 0010, 0100, 1000, 0001 (bitwise inverted for the active-low code).
- R7: From any loaded illegal state, `q` reaches a valid state within 3 shifting clocks. Examples for the active-high code (inverted for active-low): 0000 and 1001 take 1 clock, 0101 takes 2 clocks, and 0011 and 1111 take 3 clocks.
- R8: When `tst_load` is high and `rst` is low at an edge, `q` takes the value of `tst_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; loads the first state of the cycle |
| tst_load | input | 1 | Test hook: load `tst_state` into the stages |
| tst_state | input | WIDTH | Test hook: pattern to load |
| q | output | WIDTH | Stage outputs, bit 0 is the lowest stage |

## Verification
A corrupted stage appears directly at `q` in the same cycle, as either no mark or more than one mark. The correcting feedback must then remove the extra marks, one stage per clock, so a wrong recovery path shows as an invalid pattern that lasts longer than three clocks, or as a valid pattern that leaves the cycle. Each illegal pattern is loaded through the test hook in both codes. The bench counts the clocks until `q` is valid again, then follows the rotation for a full turn.

// File: rtl/ring_sc.sv
module ring_sc #(
  parameter int WIDTH      = 4,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tst_load,
  input  logic [WIDTH-1:0] tst_state,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE   = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] START = ACTIVE_LOW ? ~ONE : ONE;

  logic fb;

  generate
    if (ACTIVE_LOW) begin : g_low
      assign fb = ~&q[WIDTH-2:0];
    end else begin : g_high
      assign fb = ~|q[WIDTH-2:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           q <= START;
    else if (tst_load) q <= tst_state;
    else               q <= {q[WIDTH-2:0], fb};
  end
endmodule

// File: rtl/ring_sc_chk.sv
module ring_sc_chk #(
  parameter int WIDTH      = 4,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             tst_load,
  input logic [WIDTH-1:0] tst_state,
  input logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam int CW = $clog2(WIDTH) + 2;

  logic             armed;
  logic [CW-1:0]    bad_run;
  logic [WIDTH-1:0] hot;
  logic             shift_now;

  assign hot       = ACTIVE_LOW ? ~q : q;
  assign shift_now = !rst && !tst_load;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
    if (rst || tst_load || $countones(hot) == 1) bad_run <= '0;
    else bad_run <= bad_run + 1'b1;
  end

  assert_reset_load_R1: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    rst |=> hot == ONE);

  assert_hook_load_R8: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && tst_load) |=> q == $past(tst_state));

  assert_shift_up_R2: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    shift_now |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));

  generate
    if (ACTIVE_LOW) begin : g_low
      assert_feedback_R4: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        shift_now |=> (q[0] == 1'b0) == ($past(q[WIDTH-2:0]) == {(WIDTH-1){1'b1}}));
    end else begin : g_high
      assert_feedback_R3: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        shift_now |=> (q[0] == 1'b1) == ($past(q[WIDTH-2:0]) == '0));
    end
  endgenerate

  assert_stay_valid_R5: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    (shift_now && $countones(hot) == 1) |=> $countones(hot) == 1);

  assert_rotate_R6: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    (shift_now && $countones(hot) == 1) |=>
      hot == {$past(hot[WIDTH-2:0]), $past(hot[WIDTH-1])});

  assert_recover_R7: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    bad_run <= CW'(WIDTH - 1));
endmodule

bind ring_sc ring_sc_chk #(.WIDTH(WIDTH), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .clk(clk), .rst(rst), .tst_load(tst_load), .tst_state(tst_state), .q(q)
);

// File: tb/sim_ring_sc.sv
module sim_ring_sc;
  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       tst_load = 1'b0;
  logic [3:0] hv = 4'd0;
  logic [3:0] lv;
  logic [3:0] qh, ql;
  int checks = 0;
  int errors = 0;

  assign lv = ~hv;
  always #4 clk = ~clk;

  ring_sc #(.WIDTH(4), .ACTIVE_LOW(1'b0)) u0 (
    .clk(clk), .rst(rst), .tst_load(tst_load), .tst_state(hv), .q(qh));
  ring_sc #(.WIDTH(4), .ACTIVE_LOW(1'b1)) u1 (
    .clk(clk), .rst(rst), .tst_load(tst_load), .tst_state(lv), .q(ql));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic ld, input logic [3:0] v);
    @(negedge clk);
    rst = r; tst_load = ld; hv = v;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] rotl(input logic [3:0] x);
    return {x[2:0], x[3]};
  endfunction

  task automatic t_reset();
    step(1'b1, 1'b0, 4'd0);
    chk("R1 reset high", qh, 4'b0001);
    chk("R1 reset low", ql, 4'b1110);
  endtask

  task automatic t_sequence();
    logic [3:0] e = 4'b0001;
    step(1'b1, 1'b0, 4'd0);
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 1'b0, 4'd0);
      e = rotl(e);
      chk("R6 R2 order high", qh, e);
      chk("R6 R2 order low", ql, ~e);
    end
  endtask

  task automatic t_hook();
    step(1'b0, 1'b1, 4'b0100);
    chk("R8 hook high", qh, 4'b0100);
    chk("R8 hook low", ql, 4'b1011);
    step(1'b0, 1'b0, 4'd0);
    chk("R6 after hook high", qh, 4'b1000);
    chk("R6 after hook low", ql, 4'b0111);
    step(1'b1, 1'b1, 4'b0110);
    chk("R1 reset beats hook high", qh, 4'b0001);
    chk("R1 reset beats hook low", ql, 4'b1110);
  endtask

  task automatic t_feedback();
    step(1'b0, 1'b1, 4'b1000);
    step(1'b0, 1'b0, 4'd0);
    chk("R3 lower zero high", qh, 4'b0001);
    chk("R4 lower ones low", ql, 4'b1110);
    step(1'b0, 1'b1, 4'b1001);
    step(1'b0, 1'b0, 4'd0);
    chk("R3 lower nonzero high", qh, 4'b0010);
    chk("R4 lower not ones low", ql, 4'b1101);
  endtask

  function automatic int exp_rec(input logic [3:0] s);
    case (s)
      4'b0000, 4'b1001: return 1;
      4'b0101:          return 2;
      4'b0011, 4'b1111: return 3;
      default:          return -1;
    endcase
  endfunction

  task automatic t_recover();
    for (int s = 0; s < 16; s++) begin
      logic [3:0] sv = 4'(s);
      int nh = 0;
      int nl = 0;
      logic [3:0] e;
      if ($countones(sv) == 1) continue;
      step(1'b0, 1'b1, sv);
      chk("R8 illegal load high", qh, sv);
      chk("R8 illegal load low", ql, ~sv);
      for (int k = 1; k <= 6; k++) begin
        step(1'b0, 1'b0, 4'd0);
        if (nh == 0 && $countones(qh) == 1) nh = k;
        if (nl == 0 && $countones(~ql) == 1) nl = k;
      end
      checks++;
      if (nh < 1 || nh > 3 || nl < 1 || nl > 3) begin
        errors++;
        $display("FAIL R7 state=%b actual=%0d/%0d expected=1..3", sv, nh, nl);
      end
      if (exp_rec(sv) > 0) begin
        chk_int("R7 exact count high", nh, exp_rec(sv));
        chk_int("R7 exact count low", nl, exp_rec(sv));
      end
      e = qh;
      for (int k = 0; k < 4; k++) begin
        step(1'b0, 1'b0, 4'd0);
        e = rotl(e);
        chk("R5 stays valid high", qh, e);
        chk("R5 stays valid low", ql, ~e);
        checks++;
        if ($countones(qh) != 1) begin
          errors++;
          $display("FAIL R5 actual=%b expected=one-hot", qh);
        end
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_hook();
    t_feedback();
    t_recover();
    step(1'b1, 1'b0, 4'd0);
    chk("R1 final reset high", qh, 4'b0001);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule